// File: doc/BRIEF.md
# Prescaled System Timer with Compare Channels

The block keeps time for software. A free-running up counter advances once per prescaler tick, and a group of compare channels watch it. When an enabled channel sees the counter step onto its compare value, the channel raises a sticky flag. That flag drives the channel's own interrupt line. The flag stays up until software clears it.

Software drives the timer through a flat word-addressed register port. Writes take one cycle. Reads are combinational from the address. The port sets the run enable, the prescale ratio, the freeze-on-debug option, the per-channel enables and the compare values. It also reads the live count and reads or clears the flags. An external debug request can pause the count and the prescaler without losing their values, but only when software has armed that option.

Top module: `tick_timer`

Register map (word addresses):

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Counter |
| 2 | Channel enables, bits 3:0 |
| 3 | Flags |
| 4+i | Compare value of channel i |

Control register fields:

| Bits | Field |
|---|---|
| 0 | run |
| 1 | freeze on debug |
| 15:8 | prescale value |

## Requirements
- R1: After reset the following are all zero: every register, the counter, the prescaler divider and the interrupt lines.
- R2: The counter is 32 bits wide. It increases by exactly one on each prescaler tick while control bit 0 (run) is set, and never changes by any other amount while running.
- R3: Prescale value P is held in control bits 15:8. It gives one tick every P+1 clocks: P=0 ticks on every clock and P=255 ticks every 256th clock.
- R4: While run is clear, the counter holds and the divider returns to 0, so the first tick comes P+1 clocks after run is set. A write to address 1 loads the counter only while run is clear and is ignored while run is set.
- R5: When control bit 1 (freeze) is set and `dbgHalt` is high, the counter and the divider hold their values. When bit 1 is clear, `dbgHalt` has no effect.
- R6: Channel i sets flag i when its enable bit (address 2, bit i) is set and a tick moves the counter onto compare value i (address 4+i). `irq[i]` equals flag i, and a disabled channel never sets its flag.
- R7: Flags are sticky. Writing 1 to bit i of address 3 clears flag i, and writing 0 leaves the flag as it is. When a clear and a new match for the same channel fall in the same cycle, the flag stays set.
- R8: The counter wraps from 0xFFFFFFFF to 0 and keeps counting. A compare value of 0 matches at the wrap.
- R9: Every register reads back from its address. Address 0 reads run, freeze and the prescale value in their bit positions. Address 1 reads the live count. Address 3 reads the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| dbgHalt | input | 1 | Debug request; pauses counting when freeze is armed |
| irq | output | 4 | Per-channel interrupt lines, one per compare channel |

## Verification
The checker tests a set of properties on every cycle:
- the count moves by zero or one while running, and by exactly one at prescale 0 when not frozen;
- the count holds while stopped, except on a load, and holds while frozen;
- a flag rises only on an enabled channel;
- flags stay up unless a write occurs;
- the count wraps from all ones to zero.

Other behaviours depend on exact timing and data, so only the bench scenarios show them:
- the real tick spacing at prescale values of 3 and 255;
- the divider restarting when run is set again;
- a load ignored while running;
- a clear that collides with a match;
- a compare of zero hit at the wrap.

The bench compares these against its own cycle model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int CNT_W = 32;
  parameter int PRE_W = 8;
  parameter int NCH   = 4;

  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_EN   = 2;
  localparam int A_FLG  = 3;
  localparam int A_CMP0 = 4;
  localparam int ADDR_W = $clog2(A_CMP0 + NCH);

  localparam int B_RUN  = 0;
  localparam int B_FRZ  = 1;
  localparam int B_PRE  = 8;

  // Strobes and settings passed from the control to the datapath
  typedef struct packed {
    logic             run;
    logic             freezeEn;
    logic [PRE_W-1:0] presc;
    logic             cntLoad;
    logic [CNT_W-1:0] loadVal;
  } ctlStrobe_t;
endpackage

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strb,
  input  logic                      dbgHalt,
  input  logic [NCH-1:0][CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0]          count,
  output logic                      tick,
  output logic [NCH-1:0]            hit
);
  logic [PRE_W-1:0] div;
  logic [CNT_W-1:0] nextCnt;
  logic             frozen;

  assign frozen  = strb.freezeEn && dbgHalt;
  // >= so that lowering the prescale while running ticks at once
  assign tick    = strb.run && !frozen && (div >= strb.presc);
  assign nextCnt = count + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      div <= '0;
    end else if (!strb.run) begin
      div <= '0;
    end else if (!frozen) begin
      div <= tick ? '0 : div + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.cntLoad) begin
      count <= strb.loadVal;
    end else if (tick) begin
      count <= nextCnt;
    end
  end

  // One comparator per channel, against the value the counter is about to take
  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign hit[i] = tick && (nextCnt == cmpVal[i]);
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          wrData,
  input  logic [CNT_W-1:0]          count,
  input  logic [NCH-1:0]            hit,
  output ctlStrobe_t                strb,
  output logic [NCH-1:0][CNT_W-1:0] cmpVal,
  output logic [NCH-1:0]            chEn,
  output logic [NCH-1:0]            flags,
  output logic [CNT_W-1:0]          rdData
);
  logic             runQ;
  logic             frzQ;
  logic [PRE_W-1:0] preQ;
  logic [NCH-1:0]   setV;
  logic [NCH-1:0]   clrV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      frzQ   <= 1'b0;
      preQ   <= '0;
      chEn   <= '0;
      cmpVal <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        runQ <= wrData[B_RUN];
        frzQ <= wrData[B_FRZ];
        preQ <= wrData[B_PRE +: PRE_W];
      end
      if (addr == ADDR_W'(A_EN)) chEn <= wrData[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(A_CMP0 + i)) cmpVal[i] <= wrData;
      end
    end
  end

  // Sticky flags: a new match wins over a clear in the same cycle
  assign setV = hit & chEn;
  assign clrV = (wrEn && addr == ADDR_W'(A_FLG)) ? wrData[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrV) | setV;
  end

  always_comb begin
    strb.run      = runQ;
    strb.freezeEn = frzQ;
    strb.presc    = preQ;
    strb.cntLoad  = wrEn && (addr == ADDR_W'(A_CNT)) && !runQ;
    strb.loadVal  = wrData;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(A_CTRL): begin
        rdData[B_RUN]           = runQ;
        rdData[B_FRZ]           = frzQ;
        rdData[B_PRE +: PRE_W]  = preQ;
      end
      ADDR_W'(A_CNT): rdData = count;
      ADDR_W'(A_EN):  rdData[NCH-1:0] = chEn;
      ADDR_W'(A_FLG): rdData[NCH-1:0] = flags;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addr == ADDR_W'(A_CMP0 + i)) rdData = cmpVal[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              dbgHalt,
  output logic [NCH-1:0]    irq
);
  ctlStrobe_t                strb;
  logic [NCH-1:0][CNT_W-1:0] cmpVal;
  logic [NCH-1:0]            chEn;
  logic [NCH-1:0]            flags;
  logic [NCH-1:0]            hit;
  logic [CNT_W-1:0]          count;
  logic                      tick;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .hit(hit), .strb(strb), .cmpVal(cmpVal), .chEn(chEn),
    .flags(flags), .rdData(rdData)
  );

  tmr_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dbgHalt(dbgHalt),
    .cmpVal(cmpVal), .count(count), .tick(tick), .hit(hit)
  );

  assign irq = flags;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              dbgHalt,
  input logic [NCH-1:0]    irq,
  input logic [CNT_W-1:0]  count,
  input logic              tick,
  input logic              run,
  input logic              freezeEn,
  input logic [PRE_W-1:0]  presc,
  input logic [NCH-1:0]    chEn
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    run |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

  p_presc0_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && presc == '0 && !(freezeEn && dbgHalt)) |=> count == $past(count) + CNT_W'(1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !(wrEn && addr == ADDR_W'(A_CNT))) |=> $stable(count));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (run && freezeEn && dbgHalt) |=> $stable(count));

  p_flag_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~$past(irq) & ~$past(chEn)) == '0);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (irq & $past(irq)) == $past(irq));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count == '1) |=> count == '0);
endmodule

bind tick_timer tmr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .dbgHalt(dbgHalt),
  .irq(irq), .count(count), .tick(tick), .run(strb.run),
  .freezeEn(strb.freezeEn), .presc(strb.presc), .chEn(chEn)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  import tmr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = ADDR_W'(A_CNT);
  logic [CNT_W-1:0]  wrData = '0;
  logic [CNT_W-1:0]  rdData;
  logic              dbgHalt = 1'b0;
  logic [NCH-1:0]    irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  tick_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dbgHalt(dbgHalt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit          mRun, mFrz;
  int          mPre, mDiv;
  logic [31:0] mCnt;
  bit   [3:0]  mEn, mFlg;
  logic [31:0] mCmp [4];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mFrz = 0; mPre = 0; mDiv = 0; mCnt = 0; mEn = 0; mFlg = 0;
      foreach (mCmp[i]) mCmp[i] = 0;
    end else begin
      bit [3:0] s, c;
      s = 0;
      c = (wrEn && addr == 3) ? wrData[3:0] : 4'b0;
      if (!mRun) begin
        mDiv = 0;
        if (wrEn && addr == 1) mCnt = wrData;
      end else if (!(mFrz && dbgHalt)) begin
        if (mDiv >= mPre) begin
          mDiv = 0;
          mCnt = mCnt + 32'd1;
          for (int i = 0; i < 4; i++) if (mEn[i] && mCnt == mCmp[i]) s[i] = 1;
        end else mDiv++;
      end
      mFlg = (mFlg & ~c) | s;
      if (wrEn) begin
        if (addr == 0) begin mRun = wrData[0]; mFrz = wrData[1]; mPre = int'(wrData[15:8]); end
        if (addr == 2) mEn = wrData[3:0];
        if (addr >= 4) mCmp[addr-4] = wrData;
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      cycles++;
      chk("R6 irq", {28'b0, irq}, {28'b0, mFlg});
      if (!wrEn && addr == ADDR_W'(A_CNT)) chk("R2 count", rdData, mCnt);
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(int a, logic [31:0] d);
    wrEn = 1; addr = ADDR_W'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 0; addr = ADDR_W'(A_CNT);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(int a, output logic [31:0] v);
    addr = ADDR_W'(a); #1; v = rdData; addr = ADDR_W'(A_CNT);
  endtask

  logic [31:0] v;

  initial begin
    idle(3);
    rstN = 1; idle(1);
    // R1 / R9 reset readback
    for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 reset reg", v, 32'd0); end
    chk("R1 irq reset", {28'b0, irq}, 32'd0);

    // R9 register readback
    wr(A_CMP0 + 0, 32'd5); wr(A_CMP0 + 1, 32'd9); wr(A_CMP0 + 2, 32'd12); wr(A_CMP0 + 3, 32'd20);
    wr(A_EN, 32'h7);
    wr(A_CTRL, 32'h0000_0300);
    rd(A_CTRL, v); chk("R9 ctrl readback", v, 32'h0000_0300);
    rd(A_CMP0 + 2, v); chk("R9 cmp readback", v, 32'd12);
    rd(A_EN, v); chk("R9 enable readback", v, 32'h7);

    // R3 prescale 3: tick every 4 clocks
    wr(A_CTRL, 32'h0000_0301);
    idle(4);  rd(A_CNT, v); chk("R3 presc3 after 4", v, 32'd1);
    idle(40); rd(A_CNT, v); chk("R3 presc3 after 44", v, 32'd11);
    // R6 channels 0,1 matched; channel 3 disabled
    chk("R6 ch0 ch1 set", {28'b0, irq}, 32'h3);
    idle(40); chk("R6 ch3 disabled", {31'b0, irq[3]}, 32'd0);
    chk("R6 ch2 set", {31'b0, irq[2]}, 32'd1);

    // R7 clear with a write of 1, write of 0 keeps
    wr(A_FLG, 32'h1); rd(A_FLG, v); chk("R7 clear ch0", v, 32'h6);
    wr(A_FLG, 32'h0); rd(A_FLG, v); chk("R7 zero write keeps", v, 32'h6);
    wr(A_FLG, 32'hF);

    // R4 load ignored while running
    rd(A_CNT, v);
    wr(A_CNT, 32'h1234);
    idle(1); rd(A_CNT, v); chk("R4 load ignored", {31'b0, v == 32'h1234}, 32'd0);

    // R4 stop, load, divider restart
    wr(A_CTRL, 32'h0000_0300);
    wr(A_CNT, 32'd100);
    idle(5); rd(A_CNT, v); chk("R4 hold stopped", v, 32'd100);
    wr(A_CTRL, 32'h0000_0301);
    idle(3); rd(A_CNT, v); chk("R4 no tick before P+1", v, 32'd100);
    idle(1); rd(A_CNT, v); chk("R4 tick at P+1", v, 32'd101);

    // R5 freeze armed
    wr(A_CTRL, 32'h0000_0003);
    dbgHalt = 1; rd(A_CNT, v);
    idle(10); chk("R5 frozen", rdData, v);
    // R5 freeze not armed: debug ignored
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CNT, v);
    idle(10); chk("R5 debug ignored", rdData, v + 32'd10);
    dbgHalt = 0;

    // R7 clear colliding with match
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd200);
    wr(A_CMP0 + 0, 32'd203);
    wr(A_FLG, 32'hF);
    wr(A_CTRL, 32'h1);
    idle(2);
    wr(A_FLG, 32'h1);
    chk("R7 clear vs match", {31'b0, irq[0]}, 32'd1);

    // R8 wrap with compare 0
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'hFFFF_FFFD);
    wr(A_CMP0 + 3, 32'd0);
    wr(A_EN, 32'h8);
    wr(A_FLG, 32'hF);
    wr(A_CTRL, 32'h1);
    idle(2); rd(A_CNT, v); chk("R8 at max", v, 32'hFFFF_FFFF);
    chk("R8 no early flag", {31'b0, irq[3]}, 32'd0);
    idle(1); rd(A_CNT, v); chk("R8 wrapped", v, 32'd0);
    chk("R8 compare zero", {31'b0, irq[3]}, 32'd1);

    // R3 prescale 255
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0000_FF01);
    idle(255); rd(A_CNT, v); chk("R3 presc255 before", v, 32'd0);
    idle(1);   rd(A_CNT, v); chk("R3 presc255 tick", v, 32'd1);
    idle(512); rd(A_CNT, v); chk("R3 presc255 later", v, 32'd3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule